// File: doc/BRIEF.md
# Result Descriptor Ring Writer

This block places finished result descriptors into a circular ring in host memory. A store engine upstream hands over one descriptor per processed data segment, together with a flag that marks the final segment of a packet. For each one, the block issues a single DMA write of that descriptor to the next free slot. The slot address is the ring base plus a write pointer. The pointer advances by a programmable slot stride and returns to zero at the end of the ring.

The block keeps two counts. The processed count holds finished packets, or every descriptor in per-descriptor mode. The held count holds the ring bytes written but not yet retired by the host. An interrupt is raised while the processed count is above a programmed threshold. The interrupt is also raised while an overflow is flagged, if overflow interrupts are enabled. An overflow is any trigger that arrives while the ring has no free slot. Such a trigger is consumed and dropped.

The host sets the block up through a simple register port with 32-bit words. The addresses are: 0 ring base, 1 ring size in bytes, 2 slot geometry (descriptor length in bytes at [7:0], slot stride in bytes at [15:8]), 3 threshold (count at [15:0], counting mode at bit 31), 4 configuration, 5 status, 6 processed count, 7 held bytes, 8 write pointer. Reads of these addresses are combinational. Any other address reads zero.

Top module: `rdesc_writeback`

## Requirements
- R1: `trig_ready` is high only when the block is idle (no DMA write outstanding) and the configuration word (address 4) is nonzero. While the configuration is zero, an asserted `trig_valid` causes no DMA write and changes no count.
- R2: An accepted trigger with a free slot raises `dma_req` on the next cycle. `dma_addr` is ring base + write pointer, `dma_data` is the trigger's descriptor, and `dma_len` is geometry bits [7:0]. All of them stay stable until the cycle in which `dma_ack` is high.
- R3: When a write is acknowledged, the write pointer grows by the stride (geometry bits [15:8]). If the result is at or beyond the ring size, the pointer becomes zero instead.
- R4: When threshold bit 31 is 1 (per-packet mode), an acknowledged write adds one to the processed count only if its trigger had `trig_last` set. When bit 31 is 0, every acknowledged write adds one.
- R5: `irq` is high while the processed count is strictly greater than threshold bits [15:0]. A write to address 6 with bit 31 clear subtracts bits [15:0] from the count. A write with bit 31 set clears the count.
- R6: A trigger accepted while the held bytes are at least the ring size is dropped: no `dma_req` follows. Status bit 1 (overflow) is set, and the pointer and counts are unchanged.
- R7: Status bit 1 drives `irq` only while configuration bit 25 (overflow interrupt enable) is 1. Configuration bits [15:0] and [24:16] hold the fetch size and the fetch threshold.
- R8: Status bit 0 is set by each acknowledged write. Writing ones to status bits [7:0] clears the matching flags, and writing zeros leaves them. A flag set in the same cycle as its clear stays set. Bits [7:2] always read zero.
- R9: Each acknowledged write adds the stride to the held bytes (address 7). A write to address 7 with bit 31 clear subtracts bits [30:0], and a write with bit 31 set clears the held bytes. A write to address 8 loads the write pointer, so writing zero rewinds it to the ring base.
- R10: After reset, all registers and counts are zero. `dma_req`, `irq` and `trig_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| trig_valid | input | 1 | Store engine offers a finished descriptor |
| trig_ready | output | 1 | Block can take a descriptor |
| trig_desc | input | DESC_W | Descriptor contents |
| trig_last | input | 1 | Descriptor closes a packet |
| dma_req | output | 1 | DMA write request |
| dma_addr | output | AW | Target byte address of the slot |
| dma_len | output | 8 | Descriptor length in bytes |
| dma_data | output | DESC_W | Descriptor to write |
| dma_ack | input | 1 | DMA engine takes the request |
| irq | output | 1 | Interrupt request |

## Verification
A write pointer that has drifted shows up at `dma_addr` on the very next request. A wrong wrap shows up on the first write after the ring end. A wrong processed count or held count can be read back at addresses 6 and 7 in the cycle after the acknowledge. It also shows at `irq` in that same cycle whenever the count crosses the threshold. A full-ring check that is off by one slot shows either as a `dma_req` that should not appear or as an overflow flag set one trigger too early. Both of these are visible one cycle after the offending trigger is accepted.

// File: rtl/rdesc_writeback.sv
module rdesc_writeback #(
  parameter int AW     = 32,
  parameter int DESC_W = 64,
  parameter int CNT_W  = 16,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [DESC_W-1:0] trig_desc,
  input  logic              trig_last,
  output logic              dma_req,
  output logic [AW-1:0]     dma_addr,
  output logic [7:0]        dma_len,
  output logic [DESC_W-1:0] dma_data,
  input  logic              dma_ack,
  output logic              irq
);

  localparam logic [RA_W-1:0] A_BASE = RA_W'(0);
  localparam logic [RA_W-1:0] A_RING = RA_W'(1);
  localparam logic [RA_W-1:0] A_GEOM = RA_W'(2);
  localparam logic [RA_W-1:0] A_THR  = RA_W'(3);
  localparam logic [RA_W-1:0] A_CFG  = RA_W'(4);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(5);
  localparam logic [RA_W-1:0] A_PCNT = RA_W'(6);
  localparam logic [RA_W-1:0] A_HELD = RA_W'(7);
  localparam logic [RA_W-1:0] A_WPTR = RA_W'(8);

  logic [AW-1:0]     base_q, ring_q, held_q, wptr_q;
  logic [7:0]        dsize_q, doff_q;
  logic [CNT_W-1:0]  thr_q, pcnt_q;
  logic              pkt_mode_q, ovf_en_q, busy_q, last_q;
  logic [15:0]       fsize_q;
  logic [8:0]        fthr_q;
  logic [1:0]        stat_q;
  logic [AW-1:0]     addr_q;
  logic [DESC_W-1:0] data_q;

  logic              cfg_on, accept, full, go, ovf_hit, done, count_inc;
  logic              wr_stat, wr_pcnt, wr_held, wr_wptr;
  logic [AW:0]       nsum;
  logic [AW-1:0]     wptr_adv, held_dec;
  logic [CNT_W-1:0]  pcnt_dec;
  logic [1:0]        stat_clr;

  assign cfg_on     = (fsize_q != '0) || (fthr_q != '0) || ovf_en_q;
  assign trig_ready = cfg_on && !busy_q;
  assign accept     = trig_valid && trig_ready;
  assign full       = held_q >= ring_q;
  assign go         = accept && !full;
  assign ovf_hit    = accept && full;
  assign done       = busy_q && dma_ack;
  assign count_inc  = done && (!pkt_mode_q || last_q);

  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign wr_pcnt = reg_we && (reg_addr == A_PCNT);
  assign wr_held = reg_we && (reg_addr == A_HELD);
  assign wr_wptr = reg_we && (reg_addr == A_WPTR);

  assign nsum     = {1'b0, wptr_q} + (AW+1)'(doff_q);
  assign wptr_adv = (nsum >= {1'b0, ring_q}) ? '0 : nsum[AW-1:0];
  assign pcnt_dec = (wr_pcnt && !reg_wdata[31]) ? reg_wdata[CNT_W-1:0] : '0;
  assign held_dec = (wr_held && !reg_wdata[31]) ? AW'(reg_wdata[30:0]) : '0;
  assign stat_clr = wr_stat ? reg_wdata[1:0] : 2'b00;

  assign dma_req  = busy_q;
  assign dma_addr = addr_q;
  assign dma_data = data_q;
  assign dma_len  = dsize_q;
  assign irq      = (pcnt_q > thr_q) || (stat_q[1] && ovf_en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      ring_q     <= '0;
      dsize_q    <= '0;
      doff_q     <= '0;
      thr_q      <= '0;
      pkt_mode_q <= 1'b0;
      fsize_q    <= '0;
      fthr_q     <= '0;
      ovf_en_q   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_BASE: base_q <= AW'(reg_wdata);
        A_RING: ring_q <= AW'(reg_wdata);
        A_GEOM: begin
          dsize_q <= reg_wdata[7:0];
          doff_q  <= reg_wdata[15:8];
        end
        A_THR: begin
          thr_q      <= reg_wdata[CNT_W-1:0];
          pkt_mode_q <= reg_wdata[31];
        end
        A_CFG: begin
          fsize_q  <= reg_wdata[15:0];
          fthr_q   <= reg_wdata[24:16];
          ovf_en_q <= reg_wdata[25];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      last_q <= trig_last;
      addr_q <= base_q + wptr_q;
      data_q <= trig_desc;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      held_q <= '0;
      pcnt_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_wptr)   wptr_q <= AW'(reg_wdata);
      else if (done) wptr_q <= wptr_adv;

      if (wr_held && reg_wdata[31]) held_q <= '0;
      else held_q <= held_q - held_dec + (done ? AW'(doff_q) : '0);

      if (wr_pcnt && reg_wdata[31]) pcnt_q <= '0;
      else pcnt_q <= pcnt_q - pcnt_dec + CNT_W'(count_inc);

      stat_q <= (stat_q & ~stat_clr) | {ovf_hit, done};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_BASE: reg_rdata = 32'(base_q);
      A_RING: reg_rdata = 32'(ring_q);
      A_GEOM: reg_rdata = {16'h0, doff_q, dsize_q};
      A_THR:  reg_rdata = {pkt_mode_q, 31'(thr_q)};
      A_CFG:  reg_rdata = {6'h0, ovf_en_q, fthr_q, fsize_q};
      A_STAT: reg_rdata = {30'h0, stat_q};
      A_PCNT: reg_rdata = 32'(pcnt_q);
      A_HELD: reg_rdata = 32'(held_q);
      A_WPTR: reg_rdata = 32'(wptr_q);
      default: reg_rdata = '0;
    endcase
  end

endmodule

module rdesc_writeback_chk #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             trig_valid,
  input logic             trig_ready,
  input logic             dma_req,
  input logic             dma_ack,
  input logic [AW-1:0]    dma_addr,
  input logic             irq,
  input logic [AW-1:0]    wptr,
  input logic [AW-1:0]    ring,
  input logic [AW-1:0]    held,
  input logic             ovf,
  input logic             ovf_en,
  input logic [CNT_W-1:0] pcnt,
  input logic [CNT_W-1:0] thr
);

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !trig_ready);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_addr));

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack && !reg_we |=> (ring == '0) || (wptr < ring));

  // R6
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && (held >= ring) |=> !dma_req);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(trig_valid && trig_ready));

  // R7
  ovf_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_en && (pcnt <= thr) |-> !irq);

endmodule

bind rdesc_writeback rdesc_writeback_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
  .trig_valid(trig_valid), .trig_ready(trig_ready),
  .dma_req(dma_req), .dma_ack(dma_ack), .dma_addr(dma_addr), .irq(irq),
  .wptr(wptr_q), .ring(ring_q), .held(held_q), .ovf(stat_q[1]),
  .ovf_en(ovf_en_q), .pcnt(pcnt_q), .thr(thr_q)
);

// File: tb/rdesc_writeback_bench.sv
module rdesc_writeback_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        trig_valid = 1'b0, trig_ready, trig_last = 1'b0;
  logic [63:0] trig_desc = '0, dma_data;
  logic        dma_req, dma_ack = 1'b0, irq;
  logic [31:0] dma_addr;
  logic [7:0]  dma_len;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdesc_writeback u_rdesc_writeback (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_desc(trig_desc),
    .trig_last(trig_last), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_len(dma_len), .dma_data(dma_data), .dma_ack(dma_ack), .irq(irq)
  );

  typedef struct packed {
    logic        last;
    logic [63:0] desc;
    logic [31:0] addr;
    logic [15:0] pcnt;
    logic        irq;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{1'b0, 64'hA5A5_0000_1111_0001, 32'h1000, 16'd0, 1'b0},
    '{1'b1, 64'h0000_FFFF_2222_0002, 32'h1010, 16'd1, 1'b0},
    '{1'b1, 64'h1234_5678_9ABC_DEF0, 32'h1020, 16'd2, 1'b0},
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1030, 16'd3, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [63:0] desc, input logic last);
    @(negedge clk);
    trig_valid = 1'b1; trig_desc = desc; trig_last = last;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic ack();
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 dma_req", dma_req, 0);
    chk("R10 irq", irq, 0);
    chk("R10 trig_ready", trig_ready, 0);
    rd(4'd6, v); chk("R10 pcnt", v, 0);

    // R1: disabled configuration ignores a trigger
    send(64'h77, 1'b1);
    chk("R1 no req while disabled", dma_req, 0);
    rd(4'd6, v); chk("R1 pcnt unchanged", v, 0);

    wr(4'd0, 32'h1000);
    wr(4'd1, 32'd64);
    wr(4'd2, 32'h0000_1008);
    wr(4'd3, 32'h8000_0002);
    wr(4'd4, 32'h0200_0010);
    chk("R1 ready when enabled", trig_ready, 1);
    rd(4'd4, v); chk("R7 cfg readback", v, 32'h0200_0010);

    for (int i = 0; i < 4; i++) begin
      send(TBL[i].desc, TBL[i].last);
      chk("R2 req", dma_req, 1);
      chk("R2 addr", dma_addr, TBL[i].addr);
      chk("R2 data", dma_data, TBL[i].desc);
      chk("R2 len", dma_len, 8);
      chk("R1 busy not ready", trig_ready, 0);
      @(negedge clk);
      chk("R2 held until ack", dma_req, 1);
      ack();
      chk("R2 released", dma_req, 0);
      rd(4'd6, v); chk("R4 pcnt per packet", v, 32'(TBL[i].pcnt));
      chk("R5 irq threshold", irq, TBL[i].irq);
      rd(4'd5, v); chk("R8 written flag", v, 1);
    end
    rd(4'd7, v); chk("R9 held bytes", v, 64);
    rd(4'd8, v); chk("R3 pointer wrapped", v, 0);

    send(64'hDEAD, 1'b1);
    chk("R6 dropped", dma_req, 0);
    rd(4'd5, v); chk("R6 overflow flag", v, 3);
    rd(4'd6, v); chk("R6 pcnt unchanged", v, 3);

    wr(4'd6, 32'd2);
    rd(4'd6, v); chk("R5 decrement", v, 1);
    chk("R7 ovf irq enabled", irq, 1);
    wr(4'd4, 32'h0000_0010);
    chk("R7 ovf irq masked", irq, 0);
    wr(4'd4, 32'h0200_0010);
    chk("R7 ovf irq re-enabled", irq, 1);
    wr(4'd5, 32'h0000_0002);
    chk("R8 irq after clear", irq, 0);
    rd(4'd5, v); chk("R8 clear only bit1", v, 1);
    wr(4'd5, 32'h0000_00FD);
    rd(4'd5, v); chk("R8 clear bit0", v, 0);

    wr(4'd7, 32'd32);
    rd(4'd7, v); chk("R9 retire", v, 32);
    send(64'h5151, 1'b0);
    chk("R3 wrap address", dma_addr, 32'h1000);
    ack();
    rd(4'd6, v); chk("R4 non-last not counted", v, 1);

    wr(4'd3, 32'h0000_0002);
    send(64'h6262, 1'b0);
    chk("R3 advance address", dma_addr, 32'h1010);
    ack();
    rd(4'd6, v); chk("R4 per-descriptor count", v, 2);
    chk("R5 equal not above", irq, 0);
    rd(4'd7, v); chk("R9 held grows", v, 64);

    wr(4'd6, 32'h8000_0000);
    rd(4'd6, v); chk("R5 clear count", v, 0);
    wr(4'd7, 32'h8000_0000);
    rd(4'd7, v); chk("R9 clear held", v, 0);
    wr(4'd8, 32'h0);
    rd(4'd8, v); chk("R9 rewind pointer", v, 0);
    send(64'h7373, 1'b1);
    chk("R9 rewound address", dma_addr, 32'h1000);
    ack();

    wr(4'd4, 32'h0);
    chk("R1 disabled not ready", trig_ready, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule